// File: doc/BRIEF.md
# Direct Segment Address Translator

This block turns 48-bit virtual addresses into 41-bit physical addresses by two routes that start in the same cycle. One route is a range test against a single contiguous window of virtual space, described by three programmable registers: a lower bound, an upper bound and a displacement. An address inside the window is translated with a single subtraction, and the page-translation outcome for it is dropped. The other route is an ordinary lookup in a data TLB. The TLB sits outside the block behind a lookup interface with a fixed latency of one cycle. Outside the window a TLB hit supplies the frame number. A TLB miss raises a request to an external page-table walker and holds it until the walker acknowledges.

The three window registers belong to the running process. Software writes them and reads them back through a small select/data port so that they can be saved and restored on a context switch. At reset the window is empty: upper bound equals lower bound, both zero. Every access then goes through paging.

A state machine sequences each request. IDLE accepts a request and launches the TLB lookup together with the range test (IDLE→PROBE on accept). PROBE looks at the latched range result and the TLB answer. It goes PROBE→REPLY when the address is in the window or the TLB hits, and PROBE→WALK on a miss outside the window. WALK holds the walker request and goes WALK→REPLY on acknowledge. REPLY presents the result for one cycle and always returns REPLY→IDLE.

Top module: `dseg_xlate`

## Requirements
- R1: After reset all three window registers read back as zero, `req_ready` is 1, and `rsp_valid` and `walk_req` are 0.
- R2: An address with base <= va < limit (unsigned, all 48 bits) is translated as (va - offset) modulo 2^41, with `rsp_seg`=1.
- R3: For an address inside the window the TLB outcome is ignored: `walk_req` never rises for that request, even when the TLB misses.
- R4: Outside the window a TLB hit gives `rsp_pa` = {tlb_pfn, va[11:0]} with `rsp_tlb`=1.
- R5: Outside the window a TLB miss raises `walk_req` with `walk_vpn` = va[47:12`]`, held steady until `walk_ack`. The result is {walk_pfn, va[11:0]} with `rsp_walk`=1.
- R6: In the cycle a request is accepted, `tlb_lookup` is 1 and `tlb_vpn` = va[47:12]. This holds for every request, whether inside the window or not. The TLB answers on `tlb_hit`/`tlb_pfn` one cycle later.
- R7: When limit <= base the window is empty and every address takes the paging path.
- R8: `cfg_sel`/`cfg_rsel` code 0 selects base, 1 selects limit and 2 selects offset, each 48 bits wide. A write with `cfg_we` is readable on `cfg_rdata` from the next cycle on. Code 3 reads as zero, and a write to code 3 changes no register.
- R9: A register write that lands after a request was accepted does not change that request's result. It applies from the next accepted request.
- R10: `rsp_valid` is a one-cycle pulse two cycles after acceptance on the window and TLB-hit paths, and one cycle after `walk_ack` on the walk path. Exactly one of the three source flags is set with it. `req_ready` is 0 from acceptance until the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Write select: 0 base, 1 limit, 2 offset |
| cfg_wdata | input | 48 | Write data |
| cfg_rsel | input | 2 | Read-back select, same coding |
| cfg_rdata | output | 48 | Read-back data |
| req_valid | input | 1 | Translation request |
| req_va | input | 48 | Virtual address |
| req_ready | output | 1 | Block can accept a request |
| tlb_lookup | output | 1 | TLB lookup strobe |
| tlb_vpn | output | 36 | Virtual page number to look up |
| tlb_hit | input | 1 | TLB hit, one cycle after lookup |
| tlb_pfn | input | 29 | TLB frame number, one cycle after lookup |
| walk_req | output | 1 | Page-table walk request, held until acknowledged |
| walk_vpn | output | 36 | Page number to walk |
| walk_ack | input | 1 | Walker completion |
| walk_pfn | input | 29 | Frame number from the walker |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | 41 | Physical address |
| rsp_seg | output | 1 | Result came from the window |
| rsp_tlb | output | 1 | Result came from a TLB hit |
| rsp_walk | output | 1 | Result came from a walk |

## Verification
A stale or wrongly latched range decision shows up at the ports on the very next result. It can appear as a window address answered from the TLB, as a walk request raised inside the window, or as a flag that disagrees with the expected source. It shows no later than two cycles after acceptance. A state machine stuck in WALK or REPLY shows as `req_ready` staying low or `rsp_valid` lasting longer than one cycle, and the next request exposes it. Corrupted register contents show on read-back the cycle after the write, and in the physical address of the next window hit.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
    localparam int VA_W_DEF = 48;
    localparam int PA_W_DEF = 41;
    localparam int PG_W_DEF = 12;
    localparam int NUM_REGS = 3;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROBE = 2'd1,
        S_WALK  = 2'd2,
        S_REPLY = 2'd3
    } xl_state_e;

    typedef enum logic [1:0] {
        SRC_SEG  = 2'd0,
        SRC_TLB  = 2'd1,
        SRC_WALK = 2'd2
    } src_e;
endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
    import dseg_pkg::*;
#(
    parameter int VA_W = VA_W_DEF,
    parameter int PA_W = PA_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [VA_W-1:0] cfg_wdata,
    input  logic [1:0]      cfg_rsel,
    output logic [VA_W-1:0] cfg_rdata,
    output logic [VA_W-1:0] base,
    output logic [VA_W-1:0] limit,
    output logic [PA_W-1:0] offset_lo
);
    logic [VA_W-1:0] bank [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[i] <= '0;
            end else if (cfg_we && (cfg_sel == 2'(i))) begin
                bank[i] <= cfg_wdata;
            end
        end

        // R8: a write lands in the selected register on the next cycle
        a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (cfg_sel == 2'(i))) |=> (bank[i] == $past(cfg_wdata)));
    end

    always_comb begin
        unique case (cfg_sel_e'(cfg_rsel))
            SEL_BASE:   cfg_rdata = bank[0];
            SEL_LIMIT:  cfg_rdata = bank[1];
            SEL_OFFSET: cfg_rdata = bank[2];
            SEL_NONE:   cfg_rdata = '0;
        endcase
    end

    assign base      = bank[0];
    assign limit     = bank[1];
    assign offset_lo = bank[2][PA_W-1:0];
endmodule

// File: rtl/dseg_range.sv
module dseg_range
    import dseg_pkg::*;
#(
    parameter int VA_W = VA_W_DEF,
    parameter int PA_W = PA_W_DEF
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] limit,
    input  logic [PA_W-1:0] offset_lo,
    output logic            in_seg,
    output logic [PA_W-1:0] seg_pa
);
    logic above_base;
    logic below_limit;

    always_comb begin
        above_base  = (va >= base);
        below_limit = (va < limit);
        in_seg      = above_base && below_limit;
        // modulo 2^PA_W difference only needs the low PA_W bits
        seg_pa      = va[PA_W-1:0] - offset_lo;
    end
endmodule

// File: rtl/dseg_fsm.sv
module dseg_fsm
    import dseg_pkg::*;
#(
    parameter int VA_W = VA_W_DEF,
    parameter int PA_W = PA_W_DEF,
    parameter int PG_W = PG_W_DEF,
    localparam int VPN_W = VA_W - PG_W,
    localparam int PFN_W = PA_W - PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    input  logic             in_seg,
    input  logic [PA_W-1:0]  seg_pa,
    output logic             tlb_lookup,
    output logic [VPN_W-1:0] tlb_vpn,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_ack,
    input  logic [PFN_W-1:0] walk_pfn,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_seg,
    output logic             rsp_tlb,
    output logic             rsp_walk
);
    xl_state_e       state, state_nx;
    logic [VA_W-1:0] va_q;
    logic            seg_q;
    logic [PA_W-1:0] seg_pa_q;
    logic [PA_W-1:0] pa_q;
    src_e            src_q;
    logic            accept;

    assign accept = (state == S_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_PROBE;
            S_PROBE: state_nx = (seg_q || tlb_hit) ? S_REPLY : S_WALK;
            S_WALK:  if (walk_ack) state_nx = S_REPLY;
            S_REPLY: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers: range decision frozen at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            seg_q    <= 1'b0;
            seg_pa_q <= '0;
            pa_q     <= '0;
            src_q    <= SRC_SEG;
        end else begin
            if (accept) begin
                va_q     <= req_va;
                seg_q    <= in_seg;
                seg_pa_q <= seg_pa;
            end
            if (state == S_PROBE) begin
                if (seg_q) begin
                    pa_q  <= seg_pa_q;
                    src_q <= SRC_SEG;
                end else if (tlb_hit) begin
                    pa_q  <= {tlb_pfn, va_q[PG_W-1:0]};
                    src_q <= SRC_TLB;
                end
            end
            if ((state == S_WALK) && walk_ack) begin
                pa_q  <= {walk_pfn, va_q[PG_W-1:0]};
                src_q <= SRC_WALK;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready  = 1'b0;
        tlb_lookup = 1'b0;
        walk_req   = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready  = 1'b1;
                tlb_lookup = req_valid;
            end
            S_PROBE: ;
            S_WALK:  walk_req  = 1'b1;
            S_REPLY: rsp_valid = 1'b1;
        endcase
    end

    assign tlb_vpn  = req_va[VA_W-1:PG_W];
    assign walk_vpn = va_q[VA_W-1:PG_W];
    assign rsp_pa   = pa_q;
    assign rsp_seg  = rsp_valid && (src_q == SRC_SEG);
    assign rsp_tlb  = rsp_valid && (src_q == SRC_TLB);
    assign rsp_walk = rsp_valid && (src_q == SRC_WALK);

    // R3: a window decision never leads to a walk
    a_r3_no_walk_in_seg: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_PROBE) && seg_q) |=> (!walk_req && rsp_seg));

    // R5: walk request and page number held until acknowledged
    a_r5_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

    // R5: a walk-sourced result follows an acknowledge
    a_r5_walk_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_walk |-> $past(walk_ack));

    // R10: result is a single-cycle pulse followed by readiness
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
    import dseg_pkg::*;
#(
    parameter int VA_W = VA_W_DEF,
    parameter int PA_W = PA_W_DEF,
    parameter int PG_W = PG_W_DEF,
    localparam int VPN_W = VA_W - PG_W,
    localparam int PFN_W = PA_W - PG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [VA_W-1:0]  cfg_wdata,
    input  logic [1:0]       cfg_rsel,
    output logic [VA_W-1:0]  cfg_rdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    output logic             tlb_lookup,
    output logic [VPN_W-1:0] tlb_vpn,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_ack,
    input  logic [PFN_W-1:0] walk_pfn,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_seg,
    output logic             rsp_tlb,
    output logic             rsp_walk
);
    logic [VA_W-1:0] base, limit;
    logic [PA_W-1:0] offset_lo;
    logic            in_seg;
    logic [PA_W-1:0] seg_pa;

    dseg_regs #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .base(base), .limit(limit), .offset_lo(offset_lo)
    );

    dseg_range #(.VA_W(VA_W), .PA_W(PA_W)) u_range (
        .va(req_va), .base(base), .limit(limit), .offset_lo(offset_lo),
        .in_seg(in_seg), .seg_pa(seg_pa)
    );

    dseg_fsm #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .in_seg(in_seg), .seg_pa(seg_pa),
        .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn),
        .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_ack(walk_ack), .walk_pfn(walk_pfn),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_seg(rsp_seg), .rsp_tlb(rsp_tlb), .rsp_walk(rsp_walk)
    );

    // R7: an empty window at accept never yields a window result
    a_r7_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (limit <= base)) |-> ##2 !rsp_seg);
endmodule

// File: tb/dseg_xlate_tb.sv
`timescale 1ns/1ps
module dseg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [47:0] cfg_wdata = '0;
    logic [1:0]  cfg_rsel = 2'd0;
    logic [47:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic        req_ready;
    logic        tlb_lookup;
    logic [35:0] tlb_vpn;
    logic        tlb_hit = 1'b0;
    logic [28:0] tlb_pfn = '0;
    logic        walk_req;
    logic [35:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic [28:0] walk_pfn = '0;
    logic        rsp_valid;
    logic [40:0] rsp_pa;
    logic        rsp_seg, rsp_tlb, rsp_walk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [47:0] m_base = '0, m_limit = '0, m_off = '0;

    always #2 clk = ~clk;

    dseg_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn),
        .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_ack(walk_ack), .walk_pfn(walk_pfn),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_seg(rsp_seg), .rsp_tlb(rsp_tlb), .rsp_walk(rsp_walk)
    );

    function automatic bit f_hit(input logic [35:0] vpn);
        return vpn[3:0] < 4'd10;
    endfunction
    function automatic logic [28:0] f_tpfn(input logic [35:0] vpn);
        logic [35:0] t;
        t = vpn * 36'd7 + 36'd3;
        return t[28:0];
    endfunction
    function automatic logic [28:0] f_wpfn(input logic [35:0] vpn);
        return vpn[28:0] ^ 29'h0ABCDEF;
    endfunction

    // bench TLB: answers one cycle after each lookup
    always @(posedge clk) begin
        if (tlb_lookup) begin
            tlb_hit <= f_hit(tlb_vpn);
            tlb_pfn <= f_tpfn(tlb_vpn);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [47:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s == 2'd0) m_base = d;
        else if (s == 2'd1) m_limit = d;
        else if (s == 2'd2) m_off = d;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [47:0] exp, input string tag);
        cfg_rsel = s;
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic xlate(input logic [47:0] va, input bit mw, input logic [1:0] ms,
                         input logic [47:0] md, input string tag);
        logic [40:0] e_pa;
        int          e_src;
        logic [35:0] vpn;
        logic [40:0] d;
        bit          got, saw_walk;
        int          cyc, wcnt, lat;
        logic [40:0] a_pa;
        logic [2:0]  a_fl, e_fl;
        vpn = va[47:12];
        if ((va >= m_base) && (va < m_limit)) begin
            d = va[40:0] - m_off[40:0];
            e_pa = d; e_src = 0;
        end else if (f_hit(vpn)) begin
            e_pa = {f_tpfn(vpn), va[11:0]}; e_src = 1;
        end else begin
            e_pa = {f_wpfn(vpn), va[11:0]}; e_src = 2;
        end
        e_fl = (e_src == 0) ? 3'b100 : (e_src == 1) ? 3'b010 : 3'b001;
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_va = va;
        #1;
        chk(tlb_lookup && (tlb_vpn == vpn), {tag, " R6 lookup with accept"},
            {27'd0, tlb_lookup, tlb_vpn}, {27'd0, 1'b1, vpn});
        @(negedge clk);
        req_valid = 1'b0;
        if (mw) begin
            cfg_we = 1'b1; cfg_sel = ms; cfg_wdata = md;
        end
        chk(req_ready == 1'b0, {tag, " R10 busy after accept"}, 64'(req_ready), 64'd0);
        cyc = 1; got = 0; saw_walk = 0; wcnt = 0; lat = 0; a_pa = '0; a_fl = '0;
        while (!got && cyc < 40) begin
            if (rsp_valid) begin
                got = 1; lat = cyc; a_pa = rsp_pa; a_fl = {rsp_seg, rsp_tlb, rsp_walk};
            end else begin
                if (walk_req) begin
                    if (!saw_walk)
                        chk(walk_vpn == vpn, {tag, " R5 walk page number"}, 64'(walk_vpn), 64'(vpn));
                    saw_walk = 1; wcnt++;
                    if (wcnt == 3) begin walk_ack = 1'b1; walk_pfn = f_wpfn(vpn); end
                end
                @(negedge clk);
                if (cfg_we) begin
                    cfg_we = 1'b0;
                    if (ms == 2'd0) m_base = md;
                    else if (ms == 2'd1) m_limit = md;
                    else if (ms == 2'd2) m_off = md;
                end
                walk_ack = 1'b0;
                cyc++;
            end
        end
        chk(got, {tag, " R10 result arrives"}, 64'(got), 64'd1);
        chk(a_pa == e_pa, {tag, (e_src == 0) ? " R2 window address" :
                                (e_src == 1) ? " R4 TLB address" : " R5 walk address"},
            64'(a_pa), 64'(e_pa));
        chk(a_fl == e_fl, {tag, " R10 source flags"}, 64'(a_fl), 64'(e_fl));
        if (e_src == 0)
            chk(!saw_walk, {tag, " R3 no walk inside window"}, 64'(saw_walk), 64'd0);
        else if (e_src == 1)
            chk(!saw_walk && lat == 2, {tag, " R10 hit latency"}, 64'(lat), 64'd2);
        if (e_src == 0)
            chk(lat == 2, {tag, " R10 window latency"}, 64'(lat), 64'd2);
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R10 pulse ends"},
            {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] b, sz, va;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready at reset", 64'(req_ready), 64'd1);
        chk(!rsp_valid && !walk_req, "R1 quiet at reset", {62'd0, rsp_valid, walk_req}, 64'd0);
        for (int s = 0; s < 4; s++) rd_chk(2'(s), 48'd0, "R1 register zero at reset");

        // R7 empty window at reset: hit and miss go through paging
        xlate(48'h0000_0000_3000, 1'b0, 2'd0, '0, "R7 empty hit");
        xlate(48'h0000_0000_F123, 1'b0, 2'd0, '0, "R7 empty miss");

        // R8 program and read back
        wr(2'd0, 48'h0000_1000_0000);
        wr(2'd1, 48'h0000_2000_0000);
        wr(2'd2, 48'h0000_0F00_0000);
        rd_chk(2'd0, 48'h0000_1000_0000, "R8 base readback");
        rd_chk(2'd1, 48'h0000_2000_0000, "R8 limit readback");
        rd_chk(2'd2, 48'h0000_0F00_0000, "R8 offset readback");
        wr(2'd3, 48'hFFFF_FFFF_FFFF);
        rd_chk(2'd3, 48'd0, "R8 code 3 reads zero");
        rd_chk(2'd0, 48'h0000_1000_0000, "R8 code 3 write ignored base");
        rd_chk(2'd1, 48'h0000_2000_0000, "R8 code 3 write ignored limit");
        rd_chk(2'd2, 48'h0000_0F00_0000, "R8 code 3 write ignored offset");

        // R2 boundaries
        xlate(48'h0000_1000_0000, 1'b0, 2'd0, '0, "R2 va equals base");
        xlate(48'h0000_1FFF_FFFF, 1'b0, 2'd0, '0, "R2 va limit minus one");
        xlate(48'h0000_2000_0000, 1'b0, 2'd0, '0, "R2 va equals limit");
        xlate(48'h0000_0FFF_FFFF, 1'b0, 2'd0, '0, "R2 va below base");
        // R3 window address whose page misses in the TLB
        xlate(48'h0000_1234_F678, 1'b0, 2'd0, '0, "R3 window over TLB miss");
        // R2 offset above address wraps modulo 2^41
        wr(2'd2, 48'h0000_5000_0000);
        xlate(48'h0000_1000_0040, 1'b0, 2'd0, '0, "R2 wrapped offset");

        // R9 write during flight: disable window while request is in flight
        xlate(48'h0000_1800_0000, 1'b1, 2'd1, 48'h0000_1000_0000, "R9 in-flight disable");
        xlate(48'h0000_1800_0000, 1'b0, 2'd0, '0, "R9 next request sees new limit");

        // R7 limit below base
        wr(2'd0, 48'h0000_4000_0000);
        wr(2'd1, 48'h0000_3000_0000);
        xlate(48'h0000_3800_0000, 1'b0, 2'd0, '0, "R7 limit below base");

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 40 == 0) begin
                b  = {$urandom(), $urandom()};
                sz = 48'({$urandom()} % 32'h0100_0000) + 48'd1;
                wr(2'd0, b);
                wr(2'd1, ((i % 120) == 80) ? b : b + sz);
                wr(2'd2, {$urandom(), $urandom()});
            end
            case ($urandom() % 4)
                0, 1: va = m_base + 48'({$urandom()} % 32'h0100_0000);
                2:    va = m_limit - 48'd1 + 48'($urandom() % 3);
                default: va = {$urandom(), $urandom()};
            endcase
            xlate(va, ($urandom() % 8) == 0, 2'($urandom() % 4), {$urandom(), $urandom()},
                  "R2 R4 R5 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule